// File: doc/BRIEF.md
# Tiled Scanline Address Generator

This block produces the byte addresses a display engine needs to read one scanline of a 32-bit-per-pixel frame buffer. The buffer may be laid out in one of two ways. In the first it is a plain raster with a byte pitch between lines. In the second it uses a three-level tiled layout. That layout is built from 4x4-pixel micro-tiles of 64 bytes, 16x16-pixel subtiles of 1 KB and 32x32-pixel tiles of 4 KB. Both the order of subtiles within a tile and the order of tiles along a tile row reverse on odd tile rows.

The configuration inputs are sampled when a start pulse arrives, together with the line number. The configuration is the base address, the image width in pixels, the byte pitch and a 2-bit layout code. The block then hands out one address per pixel, from left to right, over a valid/ready handshake. It pulses a done flag once the last address has been taken. A layout code that the block does not support raises a one-cycle error pulse, and no addresses are produced for it.

Top module: `scanline_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `line_done` and `mode_err` are low.
- R2: With layout code 0 (linear), the k-th address of line y is base + y*pitch + 4*k, for k = 0 to width-1, in increasing k.
- R3: With layout code 3 (tiled), let W = ceil(width/32) and ty = y/32. The tile offset is 4096*(ty*W + c). On even ty, c = x/32. On odd ty, c = W-1-x/32.
- R4: In tiled mode, the subtile is picked from two bits. Bit 4 of y set means the top half, and clear means the bottom half. Bit 4 of x set means the right half, and clear means the left half. On even tile rows the indices are bottom-left 0, top-left 1, top-right 2 and bottom-right 3. On odd tile rows they are top-right 0, bottom-right 1, bottom-left 2 and top-left 3. The address adds 1024 times the index.
- R5: In tiled mode, the address within a subtile is 64*(4*y[3:2] + x[3:2]) + 4*(4*y[1:0] + x[1:0]).
- R6: Exactly width addresses are handed out, one per cycle with both valid and ready high. In the cycle after the last transfer, `line_done` is high for one cycle and `addr_valid` is low.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr_out` keeps its value in the next cycle.
- R8: A start with layout code 1 or 2 gives a one-cycle `mode_err` pulse in the next cycle. It produces no valid address and no `line_done`.
- R9: A start pulse during a line in progress is ignored. The remaining addresses still follow the line and configuration captured at the original start.
- R10: A start with width 0 and a supported layout gives a `line_done` pulse in the next cycle and no addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Frame buffer base byte address |
| cfg_width | input | WW | Image width in pixels |
| cfg_pitch | input | PW | Linear line pitch in bytes |
| cfg_mode | input | 2 | Layout code: 0 linear, 3 tiled, 1 and 2 unsupported |
| line_start | input | 1 | Start pulse for one scanline |
| line_y | input | LW | Line number to scan |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_out | output | AW | Pixel byte address |
| line_done | output | 1 | One-cycle pulse after the last transfer |
| mode_err | output | 1 | One-cycle pulse on an unsupported layout code |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 12-bit width and line fields, and a 16-bit pitch. It sweeps every line from 0 to 67, which covers both tile-row parities, both subtile halves and the second row of tiles. It uses widths of 1, 33 and 70 pixels, so the tile count per row is one, two or three, and the last tile is only partly filled. Whole tiles are covered by widths of 32 and 64 on selected lines. Linear lines use several pitches. A fixed irregular pattern on the ready input exercises holding under backpressure. Extra cases cover an ignored restart in the middle of a line, unsupported layout codes and a zero width.

// File: rtl/scanline_addr_gen.sv
`timescale 1ns/1ps
module scanline_addr_gen #(
  parameter int AW = 32,
  parameter int WW = 12,
  parameter int LW = 12,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [WW-1:0] cfg_width,
  input  logic [PW-1:0] cfg_pitch,
  input  logic [1:0]    cfg_mode,
  input  logic          line_start,
  input  logic [LW-1:0] line_y,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_out,
  output logic          line_done,
  output logic          mode_err
);
  localparam int TCW = WW - 4;

  logic          busy, done_q, err_q, r_tiled;
  logic [WW-1:0] x, r_width;
  logic [LW-1:0] r_y;
  logic [AW-1:0] r_base;
  logic [PW-1:0] r_pitch;

  wire start_ok   = line_start && !busy;
  wire mode_bad   = (cfg_mode == 2'd1) || (cfg_mode == 2'd2);
  wire last_pix   = (x == r_width - WW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      r_tiled <= 1'b0;
      x       <= '0;
      r_width <= '0;
      r_y     <= '0;
      r_base  <= '0;
      r_pitch <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_ok) begin
        if (mode_bad) begin
          err_q <= 1'b1;
        end else if (cfg_width == '0) begin
          done_q <= 1'b1;
        end else begin
          busy    <= 1'b1;
          x       <= '0;
          r_width <= cfg_width;
          r_y     <= line_y;
          r_base  <= cfg_base;
          r_pitch <= cfg_pitch;
          r_tiled <= (cfg_mode == 2'd3);
        end
      end else if (busy && addr_ready) begin
        if (last_pix) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          x <= x + WW'(1);
        end
      end
    end
  end

  logic [WW:0]     wid_rnd;
  logic [TCW-1:0]  tiles_per_row, tcol, tcol_eff;
  logic            odd_row;
  logic [1:0]      sub_idx;
  logic [AW-1:0]   tile_lin, lin_addr, til_addr;

  assign wid_rnd       = {1'b0, r_width} + (WW+1)'(31);
  assign tiles_per_row = wid_rnd[WW:5];
  assign tcol          = TCW'(x[WW-1:5]);
  assign odd_row       = r_y[5];
  assign tcol_eff      = odd_row ? (tiles_per_row - TCW'(1) - tcol) : tcol;
  assign tile_lin      = AW'(r_y[LW-1:5]) * AW'(tiles_per_row) + AW'(tcol_eff);
  assign sub_idx       = {x[4] ^ odd_row, x[4] ^ r_y[4]};

  assign til_addr = r_base
                  + (tile_lin << 12)
                  + (AW'(sub_idx) << 10)
                  + (AW'({r_y[3:2], x[3:2]}) << 6)
                  + (AW'({r_y[1:0], x[1:0]}) << 2);
  assign lin_addr = r_base + AW'(r_y) * AW'(r_pitch) + (AW'(x) << 2);

  assign addr_valid = busy;
  assign addr_out   = r_tiled ? til_addr : lin_addr;
  assign line_done  = done_q;
  assign mode_err   = err_q;
endmodule

// File: rtl/scanline_addr_gen_chk.sv
`timescale 1ns/1ps
module scanline_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_out,
  input logic          line_done,
  input logic          mode_err
);
  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid);
  a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> $stable(addr_out));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> !addr_valid);
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> !mode_err);
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !addr_valid && !line_done);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> !addr_valid && !line_done && !mode_err);
endmodule

bind scanline_addr_gen scanline_addr_gen_chk #(.AW(AW)) chk_i (.*);

// File: tb/scanline_addr_gen_tb_top.sv
`timescale 1ns/1ps
module scanline_addr_gen_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [31:0] cfg_base = 0;
  logic [11:0] cfg_width = 0;
  logic [15:0] cfg_pitch = 0;
  logic [1:0]  cfg_mode = 0;
  logic        line_start = 0;
  logic [11:0] line_y = 0;
  logic        addr_valid, addr_ready = 0, line_done, mode_err;
  logic [31:0] addr_out;
  int checks = 0, failures = 0, pat = 0;

  always #5 clk = ~clk;

  scanline_addr_gen dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint exp_addr(int md, int b, int w, int p, int y, int x);
    int wt, ty, tc, sub, ut, px;
    bit top, right;
    if (md == 0) return longint'(b) + y * p + 4 * x;
    wt = (w + 31) / 32; ty = y / 32; tc = x / 32;
    if (ty % 2 == 1) tc = wt - 1 - tc;
    top = (y % 32) >= 16; right = (x % 32) >= 16;
    if (ty % 2 == 0) sub = (!right && !top) ? 0 : (!right && top) ? 1 : (right && top) ? 2 : 3;
    else             sub = (right && top) ? 0 : (right && !top) ? 1 : (!right && !top) ? 2 : 3;
    ut = ((y % 16) / 4) * 4 + (x % 16) / 4;
    px = (y % 4) * 4 + (x % 4);
    return longint'(b) + (ty * wt + tc) * 4096 + sub * 1024 + ut * 64 + px * 4;
  endfunction

  task automatic run_line(input int md, input int w, input int p, input int b, input int y, input bit poke);
    int k = 0, guard = 0;
    bit have_hold = 0;
    logic [31:0] hold = 0;
    longint e;
    @(negedge clk);
    cfg_mode = 2'(md); cfg_width = 12'(w); cfg_pitch = 16'(p); cfg_base = 32'(b);
    line_y = 12'(y); line_start = 1;
    @(negedge clk);
    line_start = 0;
    while (k < w && guard < 5000) begin
      guard++;
      pat++;
      addr_ready = ((pat * 7 + 3) % 5) != 0;
      if (poke && k == 2) begin line_start = 1; line_y = 12'(y + 1); cfg_mode = 2'(3 - md); end
      else line_start = 0;
      #1;
      if (!addr_valid) begin
        chk(0, "R6 valid dropped early", 0, 1);
        guard = 5000;
      end else begin
        if (have_hold) chk(addr_out == hold, "R7 held address", addr_out, hold);
        if (addr_ready) begin
          e = exp_addr(md, b, w, p, y, k);
          if (md == 0) chk(addr_out == 32'(e), poke ? "R2 R9 linear address" : "R2 linear address", addr_out, e);
          else chk(addr_out == 32'(e), poke ? "R3 R4 R5 R9 tiled address" : "R3 R4 R5 tiled address", addr_out, e);
          k++; have_hold = 0;
        end else begin
          hold = addr_out; have_hold = 1;
        end
      end
      @(negedge clk);
    end
    line_start = 0; addr_ready = 0; cfg_mode = 2'(md);
    #1;
    chk(line_done == 1, "R6 done after last", line_done, 1);
    chk(addr_valid == 0, "R6 valid low after last", addr_valid, 0);
    @(negedge clk); #1;
    chk(line_done == 0, "R6 done one cycle", line_done, 0);
    chk(addr_valid == 0, "R6 stays idle", addr_valid, 0);
  endtask

  task automatic bad_mode(input int md);
    @(negedge clk);
    cfg_mode = 2'(md); cfg_width = 12'd20; line_y = 12'd3; line_start = 1;
    @(negedge clk); line_start = 0; #1;
    chk(mode_err == 1, "R8 error pulse", mode_err, 1);
    chk(addr_valid == 0, "R8 no address", addr_valid, 0);
    @(negedge clk); #1;
    chk(mode_err == 0, "R8 error one cycle", mode_err, 0);
    chk(addr_valid == 0 && line_done == 0, "R8 stays quiet", {addr_valid, line_done}, 0);
  endtask

  task automatic zero_width(input int md);
    @(negedge clk);
    cfg_mode = 2'(md); cfg_width = 0; line_y = 12'd5; line_start = 1;
    @(negedge clk); line_start = 0; #1;
    chk(line_done == 1 && addr_valid == 0, "R10 zero width done", {addr_valid, line_done}, 1);
    @(negedge clk); #1;
    chk(line_done == 0 && addr_valid == 0, "R10 zero width quiet", {addr_valid, line_done}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(addr_valid == 0 && line_done == 0 && mode_err == 0, "R1 reset state",
        {addr_valid, line_done, mode_err}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(addr_valid == 0 && line_done == 0 && mode_err == 0, "R1 idle after reset",
        {addr_valid, line_done, mode_err}, 0);

    for (int y = 0; y < 68; y++) begin
      run_line(3, 1, 0, 32'h0010_0000, y, 0);
      run_line(3, 33, 0, 32'h0020_0000, y, 0);
      run_line(3, 70, 0, 32'h0040_0000, y, 0);
    end
    for (int y = 0; y < 68; y += 13) begin
      run_line(3, 32, 0, 32'h0008_0000, y, 0);
      run_line(3, 64, 0, 32'h0009_0000, y, 0);
    end
    for (int y = 0; y < 40; y += 7) begin
      run_line(0, 20, 80, 32'h0001_0000, y, 0);
      run_line(0, 70, 300, 32'h0002_0040, y, 0);
    end
    run_line(0, 9, 1000, 32'h0000_1000, 4095, 0);
    run_line(3, 40, 0, 32'h0050_0000, 37, 1);
    run_line(0, 12, 64, 32'h0006_0000, 9, 1);
    bad_mode(1);
    bad_mode(2);
    zero_width(0);
    zero_width(3);
    run_line(3, 5, 0, 32'h0070_0000, 48, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule